// File: doc/BRIEF.md
# Boot/Application Privilege Gate

This block is a small register file on a 32-bit word-addressed bus. It decides whether the device is still running its trusted start-up code (firmware mode) or has handed over to a loaded program (application mode), and it enforces access rules that depend on that mode. Any write to the mode register moves the device into application mode. The move is one-way until the next power-on reset. The mode is driven out on `app_mode` so that other peripherals can block their own accesses.

In firmware mode, start-up code records three facts for the program: where it was loaded, its size, and the entry point of a hash routine. It also writes a 256-bit derived identity as eight words, and two seeds that go straight to the memory randomizer and the memory scrambler. All of these freeze once the mode flips. The derived identity stays readable in both modes. The seeds can never be read back. The device secret arrives on `uds_key`. Firmware may read each of its words once per power-up. After that first read, and at any time in application mode, the word reads as zero.

Top module: `mode_lock_ctrl`

## Requirements
- R1: After reset, `app_mode` is 0, `ready` is 0, the seed outputs are 0, and the mode register (word 0x00), the information registers and the identity words all read 0.
- R2: A write of any data value to word 0x00 sets `app_mode` at that clock edge. Later writes of any value leave it at 1, and only reset clears it. Word 0x00 reads 0x00000000 in firmware mode and 0xFFFFFFFF in application mode.
- R3: The load address (0x01), load size (0x02) and hash entry (0x03) registers take full 32-bit writes in firmware mode and read back in both modes. Writes to them in application mode are dropped.
- R4: The eight identity words at 0x20 to 0x27 take writes only in firmware mode and read back in both modes.
- R5: In firmware mode, the first read of secret word i (0x40+i) returns `uds_key[32*i+31:32*i]`. Every later read of that word returns 0 until power-on reset. Other words are not affected.
- R6: In application mode, every read of a secret word returns 0. Writes to secret words have no effect.
- R7: The randomizer seed (0x04) and scramble seed (0x05) are loaded from writes in firmware mode and appear on `mem_addr_seed` and `mem_data_seed`. Reads of them return 0. Writes to them in application mode are dropped.
- R8: A read of an unmapped word returns 0.
- R9: `ready` is 1 exactly in the cycle after a cycle with `cs` high. `rdata` holds the read result from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| cs | input | 1 | Bus access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| uds_key | input | 256 | Device secret, word i at bits 32i+31:32i |
| rdata | output | 32 | Registered read data |
| ready | output | 1 | Access completed |
| app_mode | output | 1 | 1 once application mode is entered |
| mem_addr_seed | output | 32 | Seed for address randomization |
| mem_data_seed | output | 32 | Seed for data scrambling |

## Verification
The first read of a secret word does two things at the same edge: it captures the secret into `rdata` and it marks the word as consumed. The bench reads the same word in two back-to-back cycles, with `cs` held high. The first result must equal the key word and the second must be zero, which shows that the consume flag acts from the very next access and not one cycle late. A second case also falls on a single edge: the mode switch takes effect at the same edge as the write that causes it. The bench checks this by sampling `app_mode` just before and just after that edge, and by issuing a locked write immediately after the switch.

// File: rtl/mode_lock_ctrl.sv
module mode_lock_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int KEY_WORDS = 8,
  parameter int ID_WORDS  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  input  logic [KEY_WORDS*32-1:0] uds_key,
  output logic [31:0]             rdata,
  output logic                    ready,
  output logic                    app_mode,
  output logic [31:0]             mem_addr_seed,
  output logic [31:0]             mem_data_seed
);
  // word groups are power-of-two sized and aligned to their size
  localparam int KIDX_W = $clog2(KEY_WORDS);
  localparam int IIDX_W = $clog2(ID_WORDS);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_LADDR = ADDR_W'(8'h01);
  localparam logic [ADDR_W-1:0] A_LSIZE = ADDR_W'(8'h02);
  localparam logic [ADDR_W-1:0] A_HASH  = ADDR_W'(8'h03);
  localparam logic [ADDR_W-1:0] A_RSEED = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_SSEED = ADDR_W'(8'h05);
  localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] K_BASE  = ADDR_W'(8'h40);

  logic                 mode_q, ready_q;
  logic [31:0]          laddr_q, lsize_q, hash_q, rseed_q, sseed_q, rdata_q, rd_mux;
  logic [31:0]          id_q [ID_WORDS];
  logic [KEY_WORDS-1:0] used_q;

  wire wr    = cs & we;
  wire rd    = cs & ~we;
  wire fw_wr = wr & ~mode_q;
  wire id_hit  = addr[ADDR_W-1:IIDX_W] == ID_BASE[ADDR_W-1:IIDX_W];
  wire key_hit = addr[ADDR_W-1:KIDX_W] == K_BASE[ADDR_W-1:KIDX_W];
  wire [IIDX_W-1:0] id_idx  = addr[IIDX_W-1:0];
  wire [KIDX_W-1:0] key_idx = addr[KIDX_W-1:0];
  wire key_open = key_hit & ~mode_q & ~used_q[key_idx];

  always_comb begin
    rd_mux = '0;
    if (id_hit)
      rd_mux = id_q[id_idx];
    else if (key_open)
      rd_mux = uds_key[32*key_idx +: 32];
    else
      case (addr)
        A_MODE:  rd_mux = {32{mode_q}};
        A_LADDR: rd_mux = laddr_q;
        A_LSIZE: rd_mux = lsize_q;
        A_HASH:  rd_mux = hash_q;
        default: rd_mux = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      ready_q <= 1'b0;
      rdata_q <= '0;
      laddr_q <= '0;
      lsize_q <= '0;
      hash_q  <= '0;
      rseed_q <= '0;
      sseed_q <= '0;
      used_q  <= '0;
      for (int i = 0; i < ID_WORDS; i++) id_q[i] <= '0;
    end else begin
      ready_q <= cs;
      if (rd) rdata_q <= rd_mux;
      if (rd && key_open) used_q[key_idx] <= 1'b1;
      if (wr && addr == A_MODE) mode_q <= 1'b1;
      if (fw_wr && id_hit) id_q[id_idx] <= wdata;
      if (fw_wr)
        case (addr)
          A_LADDR: laddr_q <= wdata;
          A_LSIZE: lsize_q <= wdata;
          A_HASH:  hash_q  <= wdata;
          A_RSEED: rseed_q <= wdata;
          A_SSEED: sseed_q <= wdata;
          default: ;
        endcase
    end
  end

  assign rdata         = rdata_q;
  assign ready         = ready_q;
  assign app_mode      = mode_q;
  assign mem_addr_seed = rseed_q;
  assign mem_data_seed = sseed_q;
endmodule

// File: rtl/mode_lock_ctrl_chk.sv
module mode_lock_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              ready,
  input logic              app_mode,
  input logic [31:0]       mem_addr_seed,
  input logic [31:0]       mem_data_seed
);
  assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode |=> app_mode);
  assert_mode_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == '0) |=> app_mode);
  assert_mode_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && addr == '0) |=> rdata == {32{$past(app_mode)}});
  assert_seed_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (app_mode && cs && we) |=> ($stable(mem_addr_seed) && $stable(mem_data_seed)));
  assert_secret_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (app_mode && cs && !we && addr[ADDR_W-1:3] == 5'b01000) |=> rdata == 32'h0);
  assert_ready_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs |=> ready);
  assert_ready_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !ready);
endmodule

bind mode_lock_ctrl mode_lock_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .rdata(rdata),
  .ready(ready), .app_mode(app_mode), .mem_addr_seed(mem_addr_seed),
  .mem_data_seed(mem_data_seed));

// File: tb/mode_lock_ctrl_tb.sv
`timescale 1ns/1ps
module mode_lock_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs = 1'b0, we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [255:0] uds_key;
  logic [31:0]  rdata, mem_addr_seed, mem_data_seed;
  logic         ready, app_mode;
  int tests = 0, fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  mode_lock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .uds_key(uds_key), .rdata(rdata), .ready(ready), .app_mode(app_mode),
    .mem_addr_seed(mem_addr_seed), .mem_data_seed(mem_data_seed));

  function automatic logic [31:0] key_word(int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h0000_1111;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); cs = 1'b0; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 app_mode", {31'b0, app_mode}, 32'h0);
    check("R1 ready", {31'b0, ready}, 32'h0);
    check("R1 seed", mem_addr_seed | mem_data_seed, 32'h0);
    rd(8'h00, d); check("R1 mode reg", d, 32'h0);
    rd(8'h01, d); check("R1 load addr", d, 32'h0);
    rd(8'h23, d); check("R1 id word", d, 32'h0);
  endtask

  task automatic t_fw_writes();
    logic [31:0] d;
    wr(8'h01, 32'h0000_4000); wr(8'h02, 32'h0001_2345); wr(8'h03, 32'hDEAD_BEEF);
    rd(8'h01, d); check("R3 load addr", d, 32'h0000_4000);
    rd(8'h02, d); check("R3 load size", d, 32'h0001_2345);
    rd(8'h03, d); check("R3 hash entry", d, 32'hDEAD_BEEF);
    for (int i = 0; i < 8; i++) wr(8'h20 + 8'(i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 8; i++) begin
      rd(8'h20 + 8'(i), d); check("R4 id fw readback", d, 32'hA000_0000 + 32'(i));
    end
    wr(8'h04, 32'h1357_9BDF); wr(8'h05, 32'h2468_ACE0);
    check("R7 addr seed out", mem_addr_seed, 32'h1357_9BDF);
    check("R7 data seed out", mem_data_seed, 32'h2468_ACE0);
    rd(8'h04, d); check("R7 seed read zero", d, 32'h0);
    rd(8'h05, d); check("R7 seed read zero", d, 32'h0);
    rd(8'h0F, d); check("R8 unmapped", d, 32'h0);
    rd(8'hFF, d); check("R8 unmapped", d, 32'h0);
  endtask

  task automatic t_ready();
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = 8'h03;
    check("R9 ready before edge", {31'b0, ready}, 32'h0);
    @(negedge clk); cs = 1'b0;
    check("R9 ready after access", {31'b0, ready}, 32'h1);
    check("R9 rdata", rdata, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R9 ready idle", {31'b0, ready}, 32'h0);
  endtask

  task automatic t_secret_once();
    logic [31:0] d;
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = 8'h43;
    @(negedge clk); check("R5 first read", rdata, key_word(3));
    @(negedge clk); cs = 1'b0; check("R5 second read", rdata, 32'h0);
    rd(8'h40, d); check("R5 word0 first", d, key_word(0));
    rd(8'h47, d); check("R5 word7 first", d, key_word(7));
    rd(8'h40, d); check("R5 word0 again", d, 32'h0);
    wr(8'h41, 32'hFFFF_FFFF);
    rd(8'h41, d); check("R5 word1 first after write", d, key_word(1));
  endtask

  task automatic t_switch();
    logic [31:0] d;
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = 8'h00; wdata = 32'h0;
    check("R2 before edge", {31'b0, app_mode}, 32'h0);
    @(negedge clk); cs = 1'b0; we = 1'b0;
    check("R2 after edge", {31'b0, app_mode}, 32'h1);
    rd(8'h00, d); check("R2 mode read", d, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);
    check("R2 sticky", {31'b0, app_mode}, 32'h1);
  endtask

  task automatic t_app_lock();
    logic [31:0] d;
    wr(8'h01, 32'h1111_1111); wr(8'h03, 32'h2222_2222);
    rd(8'h01, d); check("R3 app lock", d, 32'h0000_4000);
    rd(8'h03, d); check("R3 app lock", d, 32'hDEAD_BEEF);
    wr(8'h25, 32'h3333_3333);
    rd(8'h25, d); check("R4 app lock", d, 32'hA000_0005);
    wr(8'h04, 32'h0); wr(8'h05, 32'h0);
    check("R7 app lock", mem_addr_seed, 32'h1357_9BDF);
    check("R7 app lock", mem_data_seed, 32'h2468_ACE0);
    rd(8'h45, d); check("R6 unread secret hidden", d, 32'h0);
    rd(8'h42, d); check("R6 unread secret hidden", d, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) uds_key[32*i +: 32] = key_word(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_fw_writes();
    t_ready();
    t_secret_once();
    t_switch();
    t_app_lock();
    done = 1'b1;
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule